// File: doc/BRIEF.md
# Stacked Repeater Shared-Bus Arbiter

This block sits on the master device of a stack of repeaters that share one data bus. Every device in the stack has its own request line into the arbiter. On each bus clock the arbiter looks at all request lines together. If exactly one line is active, it grants the bus with an active-low acknowledge. If two or more lines are active, it does not choose a winner. Instead it withholds the acknowledge and drives an active-low collision line to every device. Both outputs are registered.

The block also holds a small receive qualifier for each device. This qualifier tells a device to capture the shared bus whenever the acknowledge is active and that device was not one of the requesters for the grant.

A strap input moves the block into external-arbitration mode. In that mode the internal decision is bypassed. The acknowledge and collision values come from two input pins and reach the devices one clock later without change. Because of this, the stack size no longer depends on how many request pins the arbiter has.

Top module: `ibus_arbiter`

## Requirements
- R1: In internal mode (ext_arb_mode = 0), when exactly one bit of `req_i` is 1 at a rising edge, `ack_n_o` is 0 and `col_n_o` is 1 from that edge on, until the next edge.
- R2: In internal mode, when two or more bits of `req_i` are 1 at a rising edge, `ack_n_o` is 1 and `col_n_o` is 0 after that edge.
- R3: In internal mode, when no bit of `req_i` is 1 at a rising edge, both `ack_n_o` and `col_n_o` are 1 after that edge.
- R4: While `rst_n` is 0, `ack_n_o` and `col_n_o` are 1 and every bit of `rx_capture_o` is 0.
- R5: Bit i of `rx_capture_o` is 1 exactly when `ack_n_o` is 0 and bit i of `req_i` was 0 at the edge that produced that `ack_n_o` value. The granted requester therefore never sees its own capture bit set.
- R6: With ext_arb_mode = 1 at a rising edge, `ack_n_o` and `col_n_o` take the values of `ext_ack_n_i` and `ext_col_n_i` at that edge, and `req_i` has no effect on them. This holds even if several requests are active at once.
- R7: The grant and collision decision is the same whichever device position (0 to NUM_DEV-1) makes the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_arb_mode | input | 1 | Strap: 1 selects external arbitration |
| req_i | input | NUM_DEV | Per-device bus request, active high |
| ext_ack_n_i | input | 1 | Acknowledge from external arbiter, active low |
| ext_col_n_i | input | 1 | Collision from external arbiter, active low |
| ack_n_o | output | 1 | Registered bus acknowledge, active low |
| col_n_o | output | 1 | Registered collision broadcast, active low |
| rx_capture_o | output | NUM_DEV | Per-device strobe telling that device to capture the shared bus |

## Verification
The bench drives a single request from each device position in turn. This shows that the grant depends on a single requester and not on its index, and it shows that the capture strobes cover every other device. It then drives adjacent pairs, split pairs and the all-active pattern, which separates a true one-hot test from a test that only checks for "any request". An idle pattern confirms the quiet state. In external mode, the bench drives conflicting request patterns against chosen external pin values, which shows that the pins win and the requests are ignored.

// File: rtl/ibus_pkg.sv
package ibus_pkg;

   typedef enum logic {
      ARB_INTERNAL = 1'b0,
      ARB_EXTERNAL = 1'b1
   } arb_mode_e;

   typedef struct packed {
      logic ack_n;
      logic col_n;
   } bus_ctl_t;

   localparam bus_ctl_t BUS_CTL_IDLE = '{ack_n: 1'b1, col_n: 1'b1};

endpackage

// File: rtl/ibus_req_decode.sv
module ibus_req_decode #(
   parameter int NUM_DEV = 4
) (
   input  logic [NUM_DEV-1:0] req,
   output logic               single,
   output logic               multi
);

   logic any_req;
   logic at_most_one;

   // one-hot test: clearing the lowest set bit must leave nothing behind
   always_comb begin
      any_req     = |req;
      at_most_one = ((req & (req - NUM_DEV'(1))) == '0);
      single      = any_req && at_most_one;
      multi       = any_req && !at_most_one;
   end

endmodule

// File: rtl/ibus_rx_qual.sv
module ibus_rx_qual #(
   parameter int NUM_DEV = 4
) (
   input  logic               ack_active,
   input  logic [NUM_DEV-1:0] req_seen,
   output logic [NUM_DEV-1:0] capture
);

   genvar g;
   generate
      for (g = 0; g < NUM_DEV; g++) begin : g_dev
         assign capture[g] = ack_active & ~req_seen[g];
      end
   endgenerate

endmodule

// File: rtl/ibus_arbiter.sv
module ibus_arbiter
   import ibus_pkg::*;
#(
   parameter int NUM_DEV = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ext_arb_mode,
   input  logic [NUM_DEV-1:0] req_i,
   input  logic               ext_ack_n_i,
   input  logic               ext_col_n_i,
   output logic               ack_n_o,
   output logic               col_n_o,
   output logic [NUM_DEV-1:0] rx_capture_o
);

   initial begin
      if (NUM_DEV < 2) $error("ibus_arbiter: NUM_DEV must be at least 2");
   end

   arb_mode_e mode;
   logic      one_req;
   logic      many_req;
   bus_ctl_t  ctl_next;
   bus_ctl_t  ctl_q;
   logic [NUM_DEV-1:0] req_q;

   assign mode = arb_mode_e'(ext_arb_mode);

   ibus_req_decode #(.NUM_DEV(NUM_DEV)) u_decode (
      .req    (req_i),
      .single (one_req),
      .multi  (many_req)
   );

   always_comb begin
      if (mode == ARB_EXTERNAL) begin
         ctl_next.ack_n = ext_ack_n_i;
         ctl_next.col_n = ext_col_n_i;
      end else begin
         ctl_next.ack_n = ~one_req;
         ctl_next.col_n = ~many_req;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= BUS_CTL_IDLE;
         req_q <= '0;
      end else begin
         ctl_q <= ctl_next;
         req_q <= req_i;
      end
   end

   assign ack_n_o = ctl_q.ack_n;
   assign col_n_o = ctl_q.col_n;

   ibus_rx_qual #(.NUM_DEV(NUM_DEV)) u_rxq (
      .ack_active (~ctl_q.ack_n),
      .req_seen   (req_q),
      .capture    (rx_capture_o)
   );

   assert_single_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_arb_mode && $onehot(req_i)) |=> (!ack_n_o && col_n_o));

   assert_multi_collide_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_arb_mode && ($countones(req_i) > 1)) |=> (ack_n_o && !col_n_o));

   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_arb_mode && (req_i == '0)) |=> (ack_n_o && col_n_o));

   assert_rx_excludes_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_arb_mode && $onehot(req_i)) |=> ((rx_capture_o & $past(req_i)) == '0));

   assert_ext_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ext_arb_mode |=> (ack_n_o == $past(ext_ack_n_i) && col_n_o == $past(ext_col_n_i)));

endmodule

// File: tb/ibus_arbiter_bench.sv
module ibus_arbiter_bench;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         ext_arb_mode;
   logic [N-1:0] req_i;
   logic         ext_ack_n_i;
   logic         ext_col_n_i;
   logic         ack_n_o;
   logic         col_n_o;
   logic [N-1:0] rx_capture_o;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   ibus_arbiter #(.NUM_DEV(N)) u_ibus_arbiter (
      .clk          (clk),
      .rst_n        (rst_n),
      .ext_arb_mode (ext_arb_mode),
      .req_i        (req_i),
      .ext_ack_n_i  (ext_ack_n_i),
      .ext_col_n_i  (ext_col_n_i),
      .ack_n_o      (ack_n_o),
      .col_n_o      (col_n_o),
      .rx_capture_o (rx_capture_o)
   );

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%0h exp=%0h", req, got, exp);
      end
   endtask

   // drive at falling edge, let one rising edge pass, sample just after it
   task automatic step(input logic ext, input logic [N-1:0] r, input logic ea, input logic ec);
      @(negedge clk);
      ext_arb_mode = ext;
      req_i        = r;
      ext_ack_n_i  = ea;
      ext_col_n_i  = ec;
      @(posedge clk);
      #1;
   endtask

   task automatic expect_internal(string tag, logic [N-1:0] r);
      int  n = $countones(r);
      logic e_ack = (n == 1) ? 1'b0 : 1'b1;
      logic e_col = (n >= 2) ? 1'b0 : 1'b1;
      logic [N-1:0] e_rx = (n == 1) ? ~r : '0;
      step(1'b0, r, 1'b1, 1'b1);
      check({tag, " ack_n"}, 32'(ack_n_o), 32'(e_ack));
      check({tag, " col_n"}, 32'(col_n_o), 32'(e_col));
      check({tag, " rx_capture R5"}, 32'(rx_capture_o), 32'(e_rx));
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      ext_arb_mode = 1'b0;
      req_i = '1;
      ext_ack_n_i = 1'b0;
      ext_col_n_i = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check("R4 ack_n", 32'(ack_n_o), 32'(1));
      check("R4 col_n", 32'(col_n_o), 32'(1));
      check("R4 rx_capture", 32'(rx_capture_o), 32'(0));
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic test_single();
      for (int i = 0; i < N; i++) begin
         expect_internal("R1 R7 single", N'(1) << i);
      end
   endtask

   task automatic test_multi();
      expect_internal("R2 pair low", 4'b0011);
      expect_internal("R2 pair split", 4'b1001);
      expect_internal("R2 three", 4'b0111);
      expect_internal("R2 all", 4'b1111);
      expect_internal("R1 after collision", 4'b0100);
   endtask

   task automatic test_idle();
      expect_internal("R3 idle", 4'b0000);
   endtask

   task automatic test_ext();
      step(1'b1, 4'b0001, 1'b1, 1'b0);
      check("R6 ext col ack_n", 32'(ack_n_o), 32'(1));
      check("R6 ext col col_n", 32'(col_n_o), 32'(0));
      check("R6 ext col rx", 32'(rx_capture_o), 32'(0));
      step(1'b1, 4'b1110, 1'b0, 1'b1);
      check("R6 ext grant ack_n", 32'(ack_n_o), 32'(0));
      check("R6 ext grant col_n", 32'(col_n_o), 32'(1));
      check("R5 ext grant rx", 32'(rx_capture_o), 32'(4'b0001));
      step(1'b1, 4'b0000, 1'b0, 1'b0);
      check("R6 ext both ack_n", 32'(ack_n_o), 32'(0));
      check("R6 ext both col_n", 32'(col_n_o), 32'(0));
      step(1'b1, 4'b0010, 1'b1, 1'b1);
      check("R6 ext quiet ack_n", 32'(ack_n_o), 32'(1));
      check("R6 ext quiet col_n", 32'(col_n_o), 32'(1));
      expect_internal("R1 back to internal", 4'b1000);
   endtask

   initial begin
      fork
         begin
            test_reset();
            test_single();
            test_multi();
            test_idle();
            test_ext();
         end
         begin
            repeat (5000) @(posedge clk);
            failures++;
            checks++;
            $display("FAIL watchdog expired got=1 exp=0");
         end
      join_any
      disable fork;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule